// File: doc/BRIEF.md
# Delayed Power-On Reset Generator

This block makes the single startup reset for a processor subsystem. Once the system clock runs, and once an optional clock-stable qualifier has been seen high, a delay counter advances by one on every rising clock edge. When it reaches a programmed terminal value it raises a one-cycle event. The event is too short to reset a processor reliably, so a stretcher turns it into an active-low reset pulse of a fixed number of clock cycles.

The block is one-shot. The output is high from power-up, goes low once, and then stays high for good. After firing, the delay counter freezes, so it can never wrap round and fire again. The qualifier is asynchronous and passes through a synchronizer first. While it is low before the pulse, the delay counter is held at zero, so the delay always restarts from the beginning.

All registers take their power-up value from their declarations. The block has no reset input of its own. A parameter can remove the qualifier path, so the delay then starts at the first clock edge. The output is a control pin, not a data stream, so it has no handshake.

Top module: `por_reset_gen`

## Requirements
- R1: From power-up until the pulse, rst_n_o is 1.
- R2: While the synchronized qualifier is 0 and the pulse has not yet fired, the delay count stays at 0. The delay always starts from zero once the qualifier is high again.
- R3: With USE_LOCK=1 and SYNC_STAGES=2, suppose lock_i rises between two edges and stays high. Call the first rising edge after the rise edge 1. Then rst_n_o goes to 0 right after edge SYNC_STAGES+TERM_CNT+1, which is edge 252 for the defaults.
- R4: rst_n_o stays 0 for exactly PULSE_LEN clock cycles (5 by default), then returns to 1.
- R5: After the pulse, the delay counter saturates. No second pulse ever follows, whatever lock_i does.
- R6: With USE_LOCK=0, lock_i has no effect, and rst_n_o goes to 0 right after rising edge TERM_CNT+1, counting the first edge after power-up as edge 1.
- R7: rst_n_o changes only on the rising edge of clk_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; all state changes on its rising edge |
| lock_i | input | 1 | Asynchronous clock-stable qualifier, active high |
| rst_n_o | output | 1 | Registered active-low reset pulse |

## Verification
The qualifier is driven in three patterns.

- Held low after power-up: shows that nothing counts while the clock is unstable.
- Raised and then dropped partway through the delay: a design that resumes the count instead of restarting it fires early, and the edge-exact fall position catches this.
- Toggled many times after the pulse: this catches a counter that wraps, or a stretcher that retriggers.

A second instance with the qualifier removed and short parameters runs alongside. It separates the ungated delay and a different pulse length from the defaults.

// File: rtl/por_pkg.sv
package por_pkg;
  // Width needed to hold values 0..n
  function automatic int cnt_bits(input int n);
    int w;
    w = 1;
    while ((1 << w) <= n) w++;
    return w;
  endfunction
endpackage

// File: rtl/por_lock_sync.sv
module por_lock_sync #(
  parameter int USE_LOCK    = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic lock_i,
  output logic lock_s_o
);
  generate
    if (USE_LOCK != 0) begin : g_sync
      logic [SYNC_STAGES-1:0] sh_q = '0;
      always_ff @(posedge clk_i) begin
        sh_q <= {sh_q[SYNC_STAGES-2:0], lock_i};
      end
      assign lock_s_o = sh_q[SYNC_STAGES-1];
    end else begin : g_nosync
      assign lock_s_o = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/por_delay_counter.sv
module por_delay_counter #(
  parameter int CNT_W    = 20,
  parameter int TERM_CNT = 249
) (
  input  logic clk_i,
  input  logic run_i,
  output logic tick_o,
  output logic done_o
);
  localparam logic [CNT_W-1:0] TERM = CNT_W'(TERM_CNT);

  logic [CNT_W-1:0] cnt_q  = '0;
  logic             done_q = 1'b0;

  always_ff @(posedge clk_i) begin
    if (!done_q) begin
      if (!run_i) begin
        cnt_q <= '0;
      end else if (cnt_q == TERM) begin
        done_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign tick_o = run_i && !done_q && (cnt_q == TERM);
  assign done_o = done_q;

  // R2: qualifier low before firing clears the delay
  a_r2_hold_zero: assert property (@(posedge clk_i) (!run_i && !done_q) |=> (cnt_q == '0));
  // R5: counter frozen after firing
  a_r5_no_wrap: assert property (@(posedge clk_i) done_q |=> (done_q && $stable(cnt_q)));
  // R2: counter advances by exactly one while running
  a_r2_step: assert property (@(posedge clk_i) disable iff (!run_i)
    (!done_q && cnt_q != TERM) |=> (cnt_q == $past(cnt_q) + 1'b1 || !run_i));
endmodule

// File: rtl/por_pulse_stretch.sv
module por_pulse_stretch
  import por_pkg::*;
#(
  parameter int PULSE_LEN = 5
) (
  input  logic clk_i,
  input  logic fire_i,
  output logic rst_n_o
);
  localparam int RW = cnt_bits(PULSE_LEN);
  localparam logic [RW-1:0] LEN = RW'(PULSE_LEN);

  logic [RW-1:0] rem_q   = '0;
  logic          rst_n_q = 1'b1;

  always_ff @(posedge clk_i) begin
    if (fire_i) begin
      rem_q   <= LEN;
      rst_n_q <= 1'b0;
    end else if (rem_q > RW'(1)) begin
      rem_q <= rem_q - 1'b1;
    end else if (rem_q == RW'(1)) begin
      rem_q   <= '0;
      rst_n_q <= 1'b1;
    end
  end

  assign rst_n_o = rst_n_q;

  // R4: reset asserted on the edge after the event
  a_r4_fire_low: assert property (@(posedge clk_i) fire_i |=> !rst_n_q);
  // R4: output low exactly while cycles remain
  a_r4_low_remaining: assert property (@(posedge clk_i) (rem_q != '0) |-> !rst_n_q);
  a_r4_release: assert property (@(posedge clk_i) (rem_q == RW'(1) && !fire_i) |=> rst_n_q);
endmodule

// File: rtl/por_reset_gen.sv
module por_reset_gen #(
  parameter int CNT_W       = 20,
  parameter int TERM_CNT    = 249,
  parameter int PULSE_LEN   = 5,
  parameter int USE_LOCK    = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic lock_i,
  output logic rst_n_o
);
  logic lock_s;
  logic tick;
  logic done;

  por_lock_sync #(.USE_LOCK(USE_LOCK), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .lock_i(lock_i), .lock_s_o(lock_s));

  por_delay_counter #(.CNT_W(CNT_W), .TERM_CNT(TERM_CNT)) u_cnt (
    .clk_i(clk_i), .run_i(lock_s), .tick_o(tick), .done_o(done));

  por_pulse_stretch #(.PULSE_LEN(PULSE_LEN)) u_str (
    .clk_i(clk_i), .fire_i(tick), .rst_n_o(rst_n_o));

  // R1: high until the delay has expired
  a_r1_idle_high: assert property (@(posedge clk_i) !done |-> rst_n_o);
  // R5: one event per power-up
  a_r5_single: assert property (@(posedge clk_i) done |-> !tick);
endmodule

// File: tb/por_reset_gen_tb.sv
`timescale 1ns/1ps
module por_reset_gen_tb;
  localparam int TERM = 249, PULSE = 5, SYNC = 2;
  localparam int TERM2 = 20, PULSE2 = 3;

  logic clk = 0;
  logic lock = 0;
  logic rst_n, rst_n2;
  int   tests = 0, fails = 0;
  int   ecount = 0;

  always #2 clk = ~clk;

  por_reset_gen u_dut (.clk_i(clk), .lock_i(lock), .rst_n_o(rst_n));
  por_reset_gen #(.CNT_W(8), .TERM_CNT(TERM2), .PULSE_LEN(PULSE2), .USE_LOCK(0))
    u_dut_nolock (.clk_i(clk), .lock_i(lock), .rst_n_o(rst_n2));

  // behavioural reference models
  bit s_q[$];
  bit fired = 0; int n = 0; int left = 0; bit exp1 = 1;
  bit fired2 = 0; int n2 = 0; int left2 = 0; bit exp2 = 1;
  initial for (int i = 0; i < SYNC; i++) s_q.push_back(1'b0);

  always @(posedge clk) begin
    bit ls;
    ecount++;
    ls = s_q[SYNC-1];
    if (!fired) begin
      if (!ls) n = 0;
      else if (n == TERM) begin fired = 1; left = PULSE; end
      else n++;
    end else if (left > 0) left--;
    void'(s_q.pop_back());
    s_q.push_front(lock);
    exp1 = (left == 0);
    if (!fired2) begin
      if (n2 == TERM2) begin fired2 = 1; left2 = PULSE2; end else n2++;
    end else if (left2 > 0) left2--;
    exp2 = (left2 == 0);
  end

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // per-cycle comparison and event capture, away from the active edge
  bit prev1 = 1, prev2 = 1;
  int falls1 = 0, fall1_edge = -1, low1 = 0;
  int falls2 = 0, fall2_edge = -1, low2 = 0;
  always @(negedge clk) begin
    chk(fired ? (left > 0 ? "R4 main" : "R5 main") : "R1 main", rst_n, exp1);
    chk(fired2 ? "R6 nolock pulse" : "R6 nolock idle", rst_n2, exp2);
    if (prev1 && !rst_n) begin falls1++; fall1_edge = ecount; end
    if (prev2 && !rst_n2) begin falls2++; fall2_edge = ecount; end
    if (!rst_n) low1++;
    if (!rst_n2) low2++;
    prev1 = rst_n; prev2 = rst_n2;
  end

  // R7: no change away from the rising edge
  always @(rst_n or rst_n2) begin
    if ($time > 0 && clk !== 1'b1) chk("R7 change off rising edge", 0, 1);
  end

  int rise_edge;
  initial begin
    @(negedge clk);
    chk("R1 reset state", rst_n, 1);
    repeat (40) @(negedge clk);
    chk("R2 no pulse with lock low", falls1, 0);
    lock = 1;
    repeat (150) @(negedge clk);
    lock = 0;                       // dropped partway: delay must restart
    repeat (10) @(negedge clk);
    chk("R2 no early pulse after restart", falls1, 0);
    lock = 1;
    rise_edge = ecount;
    repeat (300) @(negedge clk);
    chk("R3 fall edge position", fall1_edge, rise_edge + SYNC + TERM + 1);
    chk("R4 low cycle count", low1, PULSE);
    for (int k = 0; k < 40; k++) begin
      lock = ~lock;
      repeat (k % 7 + 1) @(negedge clk);
    end
    lock = 1;
    repeat (2500) @(negedge clk);
    chk("R5 single pulse main", falls1, 1);
    chk("R5 output high after pulse", rst_n, 1);
    chk("R6 nolock fall edge", fall2_edge, TERM2 + 1);
    chk("R6 nolock low count", low2, PULSE2);
    chk("R6 nolock single pulse", falls2, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #100000;
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule